// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

A 16-bit timer-counter peripheral for a small microcontroller subsystem. Software reaches it through a byte-wide register port: one control byte, one mode byte, two count bytes and two capture/reload bytes. The count advances in one of two ways. In timer use it moves on every machine-cycle tick. In counter use it moves on every falling edge seen on the count pin.

A second pin, the trigger pin, is sampled on the same ticks. Depending on the control bits, a falling edge on this pin captures the running count or forces a reload. In up/down operation its level picks the count direction instead. When either serial-clock select bit is set, the block becomes a baud-clock source. It then reloads on every wrap and sends a one-clock pulse to the serial port. In this mode it does not raise the overflow flag.

The interrupt request combines the two sticky flags. Priority handling is left to the interrupt controller.

Top module: `cr_timer16`

## Requirements
- R1: After synchronous reset every register reads 0x00, and `irq` and `ovf_pulse` are low.
- R2: Register addresses are: 0 control, 1 mode, 2 count low, 3 count high, 4 capture low, 5 capture high; addresses 6 and 7 read 0x00. Control bits 7..0 are: overflow flag, external flag, receive-clock select, transmit-clock select, trigger enable, run, counter select (1 = count pin, 0 = tick), capture select. Mode bit 0 is down-count enable; its other bits read 0.
- R3: With run set and counter select 0, the count rises by one per clock in which `tick` is high. With run clear, the count holds.
- R4: With counter select 1, pins are sampled on ticks. The count rises by one in the tick after a tick whose sample is low while the previous sample was high. A pin that stays low or stays high adds nothing.
- R5: Capture mode (run, both clock selects 0, capture select 1). Stepping past 0xFFFF gives 0x0000 and sets the overflow flag. A trigger falling edge with trigger enable 1 copies the count into the capture pair and sets the external flag. With trigger enable 0, the edge changes nothing.
- R6: Auto-reload mode (capture select 0, down-count 0). Stepping at 0xFFFF loads the capture pair and sets the overflow flag. A trigger falling edge with trigger enable 1 loads the capture pair and sets the external flag.
- R7: Auto-reload with down-count 1. A sampled trigger level 0 counts down and a level 1 counts up. Counting down from a count equal to the capture pair loads 0xFFFF. Counting up from 0xFFFF loads the capture pair. Each such wrap sets the overflow flag and toggles the external flag. Trigger edges then cause no reload.
- R8: Baud mode (run with either clock select set, regardless of capture select). Stepping at 0xFFFF loads the capture pair and drives `ovf_pulse` high for exactly the following clock. The overflow flag stays clear, and trigger edges are ignored.
- R9: `irq` is high when the overflow flag is set, or when the external flag is set while down-count is 0.
- R10: The flags stay set until software writes the control byte. If a hardware set and a software write land in the same cycle, the flag ends up set.
- R11: A write to a count byte in a cycle where the count would step replaces only that byte. That cycle's step, and any overflow it would cause, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle enable |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Capture/reload trigger and direction input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-clock baud overflow pulse |

## Verification
The bench builds the block with its default 16-bit count formed from two 8-bit bytes, and holds `tick` high so that every clock is one machine cycle. It preloads the count a few steps short of 0xFFFF, or of the capture value, through the register port. This puts every wrap, reload, down-count underflow and same-cycle write collision within a handful of clocks. A full 256-step baud period is also covered by loading a capture value of 0xFF00.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd5;

    typedef enum logic [1:0] {
        M_OFF,
        M_RELOAD,
        M_CAPTURE,
        M_BAUD
    } tmode_e;

    // Field order is software visible (bit 7 first).
    typedef struct packed {
        logic ovf_flag;
        logic ext_flag;
        logic rx_clk;
        logic tx_clk;
        logic ext_en;
        logic run;
        logic cnt_sel;
        logic cap_sel;
    } ctrl_t;

    function automatic tmode_e decode_mode(ctrl_t c);
        if (!c.run)
            return M_OFF;
        if (c.rx_clk || c.tx_clk)
            return M_BAUD;
        return c.cap_sel ? M_CAPTURE : M_RELOAD;
    endfunction

endpackage

// File: rtl/crt_fall_det.sv
module crt_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic level,
    output logic fall
);

    logic samp_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else if (tick) begin
            samp_q <= pin;
            prev_q <= samp_q;
        end
    end

    assign level = samp_q;
    assign fall  = tick & prev_q & ~samp_q;

endmodule

// File: rtl/crt_core.sv
module crt_core
    import crt_pkg::*;
#(
    parameter int CNT_W  = 16,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  tmode_e            mode,
    input  logic              step,
    input  logic              dcen,
    input  logic              up,
    input  logic              ext_edge,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic              wr_cap_lo,
    input  logic              wr_cap_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  cap,
    output logic              wrap,
    output logic              ext_hit
);

    localparam logic [CNT_W-1:0] ALL1 = '1;

    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] cap_q, cap_n;

    always_comb begin
        cnt_n   = cnt_q;
        cap_n   = cap_q;
        wrap    = 1'b0;
        ext_hit = 1'b0;

        if (step) begin
            case (mode)
                M_CAPTURE: begin
                    cnt_n = cnt_q + 1'b1;
                    wrap  = (cnt_q == ALL1);
                end
                M_RELOAD, M_BAUD: begin
                    if (mode == M_RELOAD && dcen && !up) begin
                        if (cnt_q == cap_q) begin
                            cnt_n = ALL1;
                            wrap  = 1'b1;
                        end else begin
                            cnt_n = cnt_q - 1'b1;
                        end
                    end else if (cnt_q == ALL1) begin
                        cnt_n = cap_q;
                        wrap  = 1'b1;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (wr_cap_lo) cap_n[HALF_W-1:0]     = wdata;
        if (wr_cap_hi) cap_n[CNT_W-1:HALF_W] = wdata;

        if (ext_edge) begin
            if (mode == M_CAPTURE) begin
                cap_n   = cnt_q;
                ext_hit = 1'b1;
            end else if (mode == M_RELOAD && !dcen) begin
                cnt_n   = cap_q;
                ext_hit = 1'b1;
            end
        end

        if (wr_cnt_lo || wr_cnt_hi) begin
            cnt_n = cnt_q;
            wrap  = 1'b0;
            if (wr_cnt_lo) cnt_n[HALF_W-1:0]     = wdata;
            if (wr_cnt_hi) cnt_n[CNT_W-1:HALF_W] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else begin
            cnt_q <= cnt_n;
            cap_q <= cap_n;
        end
    end

    assign cnt = cnt_q;
    assign cap = cap_q;

endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    output logic              ovf_pulse
);

    localparam int CNT_W = 2 * BYTE_W;
    localparam int NPIN  = 2;
    localparam int P_CNT = 0;
    localparam int P_TRG = 1;

    ctrl_t            ctrl_q, ctrl_n;
    logic             dcen_q;
    tmode_e           mode;
    logic [NPIN-1:0]  pin_v, pin_lvl, pin_fall;
    logic [CNT_W-1:0] cnt_v, cap_v;
    logic             wrap, ext_hit, step, ext_edge, cnt_fall, cnt_sel, ovf_flag;
    logic             wr_ctrl, wr_mode, wr_cnt_lo, wr_cnt_hi, wr_cap_lo, wr_cap_hi;
    logic             wr_cnt_any, wr_cap_any;

    assign mode     = decode_mode(ctrl_q);
    assign pin_v    = {trig_pin, cnt_pin};

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        crt_fall_det u_det (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .pin   (pin_v[i]),
            .level (pin_lvl[i]),
            .fall  (pin_fall[i])
        );
    end

    assign cnt_fall = pin_fall[P_CNT];
    assign cnt_sel  = ctrl_q.cnt_sel;
    assign step     = cnt_sel ? cnt_fall : tick;
    assign ext_edge = pin_fall[P_TRG] & ctrl_q.ext_en;
    assign ovf_flag = ctrl_q.ovf_flag;

    assign wr_ctrl    = wr_en && (addr == A_CTRL);
    assign wr_mode    = wr_en && (addr == A_MODE);
    assign wr_cnt_lo  = wr_en && (addr == A_CNT_LO);
    assign wr_cnt_hi  = wr_en && (addr == A_CNT_HI);
    assign wr_cap_lo  = wr_en && (addr == A_CAP_LO);
    assign wr_cap_hi  = wr_en && (addr == A_CAP_HI);
    assign wr_cnt_any = wr_cnt_lo | wr_cnt_hi;
    assign wr_cap_any = wr_cap_lo | wr_cap_hi;

    crt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .step      (step),
        .dcen      (dcen_q),
        .up        (pin_lvl[P_TRG]),
        .ext_edge  (ext_edge),
        .wr_cnt_lo (wr_cnt_lo),
        .wr_cnt_hi (wr_cnt_hi),
        .wr_cap_lo (wr_cap_lo),
        .wr_cap_hi (wr_cap_hi),
        .wdata     (wdata),
        .cnt       (cnt_v),
        .cap       (cap_v),
        .wrap      (wrap),
        .ext_hit   (ext_hit)
    );

    // Hardware flag events are applied after the software write.
    always_comb begin
        ctrl_n = ctrl_q;
        if (wr_ctrl)
            ctrl_n = ctrl_t'(wdata);
        if (wrap && mode == M_RELOAD && dcen_q)
            ctrl_n.ext_flag = ~ctrl_q.ext_flag;
        if (ext_hit)
            ctrl_n.ext_flag = 1'b1;
        if (wrap && mode != M_BAUD)
            ctrl_n.ovf_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            dcen_q    <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_n;
            ovf_pulse <= wrap && (mode == M_BAUD);
            if (wr_mode)
                dcen_q <= wdata[0];
        end
    end

    assign irq = ctrl_q.ovf_flag | (ctrl_q.ext_flag & ~dcen_q);

    always_comb begin
        case (addr)
            A_CTRL:   rdata = ctrl_q;
            A_MODE:   rdata = {{(BYTE_W-1){1'b0}}, dcen_q};
            A_CNT_LO: rdata = cnt_v[BYTE_W-1:0];
            A_CNT_HI: rdata = cnt_v[CNT_W-1:BYTE_W];
            A_CAP_LO: rdata = cap_v[BYTE_W-1:0];
            A_CAP_HI: rdata = cap_v[CNT_W-1:BYTE_W];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/crt_checker.sv
module crt_checker
    import crt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input tmode_e           mode,
    input logic             ovf_flag,
    input logic             ovf_pulse,
    input logic [CNT_W-1:0] cnt_v,
    input logic [CNT_W-1:0] cap_v,
    input logic             wr_ctrl,
    input logic             wr_cnt_any,
    input logic             wr_cap_any,
    input logic             ext_edge,
    input logic             cnt_fall,
    input logic             cnt_sel
);

    a_r3_off_holds: assert property (@(posedge clk) disable iff (rst)
        (mode == M_OFF && !wr_cnt_any) |=> $stable(cnt_v));

    a_r4_no_edge_no_step: assert property (@(posedge clk) disable iff (rst)
        (mode != M_OFF && cnt_sel && !cnt_fall && !wr_cnt_any && !ext_edge) |=> $stable(cnt_v));

    a_r5_cap_only_in_capture: assert property (@(posedge clk) disable iff (rst)
        (mode != M_CAPTURE && !wr_cap_any) |=> $stable(cap_v));

    a_r8_no_flag_in_baud: assert property (@(posedge clk) disable iff (rst)
        (mode == M_BAUD && !wr_ctrl) |=> !$rose(ovf_flag));

    a_r8_pulse_from_baud: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> $past(mode == M_BAUD));

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !wr_ctrl) |=> ovf_flag);

endmodule

bind cr_timer16 crt_checker #(.CNT_W(2 * crt_pkg::BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .ovf_flag   (ovf_flag),
    .ovf_pulse  (ovf_pulse),
    .cnt_v      (cnt_v),
    .cap_v      (cap_v),
    .wr_ctrl    (wr_ctrl),
    .wr_cnt_any (wr_cnt_any),
    .wr_cap_any (wr_cap_any),
    .ext_edge   (ext_edge),
    .cnt_fall   (cnt_fall),
    .cnt_sel    (cnt_sel)
);

// File: tb/cr_timer16_bench.sv
module cr_timer16_bench;
    import crt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b1;
    logic              cnt_pin = 1'b1;
    logic              trig_pin = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [BYTE_W-1:0] wdata = '0;
    logic [BYTE_W-1:0] rdata;
    logic              irq, ovf_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cr_timer16 u_cr_timer16 (
        .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .ovf_pulse(ovf_pulse)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [BYTE_W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [ADDR_W-1:0] a, int exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic cnt_chk(string req, int exp);
        rd_chk(req, A_CNT_LO, exp & 8'hFF);
        rd_chk(req, A_CNT_HI, (exp >> 8) & 8'hFF);
    endtask

    task automatic cap_chk(string req, int exp);
        rd_chk(req, A_CAP_LO, exp & 8'hFF);
        rd_chk(req, A_CAP_HI, (exp >> 8) & 8'hFF);
    endtask

    task automatic steps(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cnt(int v);
        wr(A_CNT_LO, v[7:0]);
        wr(A_CNT_HI, v[15:8]);
    endtask

    task automatic set_cap(int v);
        wr(A_CAP_LO, v[7:0]);
        wr(A_CAP_HI, v[15:8]);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) rd_chk("R1/R2 reset value", a[ADDR_W-1:0], 0);
        check("R1 irq at reset", irq, 0);
        check("R1 pulse at reset", ovf_pulse, 0);
        wr(A_MODE, 8'hFF);
        rd_chk("R2 mode unused bits", A_MODE, 8'h01);
        wr(A_MODE, 8'h00);
    endtask

    task automatic t_timer;
        set_cnt(16'h0010);
        wr(A_CTRL, 8'h04);
        steps(5);
        cnt_chk("R3 timer steps", 16'h0015);
        wr(A_CTRL, 8'h00);
        steps(4);
        cnt_chk("R3 off holds", 16'h0016);
    endtask

    task automatic t_counter;
        wr(A_CTRL, 8'h00);
        set_cnt(16'h0100);
        wr(A_CTRL, 8'h06);
        steps(3);
        cnt_chk("R4 high level no count", 16'h0100);
        cnt_pin = 1'b0;
        steps(1);
        cnt_chk("R4 not yet", 16'h0100);
        steps(1);
        cnt_chk("R4 one edge", 16'h0101);
        steps(3);
        cnt_chk("R4 low level no count", 16'h0101);
        cnt_pin = 1'b1;
        steps(2);
        cnt_pin = 1'b0;
        steps(2);
        cnt_chk("R4 second edge", 16'h0102);
        cnt_pin = 1'b1;
        steps(2);
    endtask

    task automatic t_capture;
        wr(A_CTRL, 8'h00);
        set_cnt(16'h1234);
        wr(A_CTRL, 8'h0F);
        trig_pin = 1'b0;
        steps(2);
        cap_chk("R5 capture copy", 16'h1234);
        rd_chk("R5 external flag", A_CTRL, 8'h4F);
        check("R9 irq from ext", irq, 1);
        trig_pin = 1'b1;
        steps(2);
        wr(A_CTRL, 8'h07);
        set_cnt(16'h5678);
        trig_pin = 1'b0;
        steps(2);
        cap_chk("R5 trigger ignored", 16'h1234);
        rd_chk("R5 no flag when disabled", A_CTRL, 8'h07);
        trig_pin = 1'b1;
        steps(2);
        wr(A_CTRL, 8'h00);
        set_cnt(16'hFFFE);
        wr(A_CTRL, 8'h05);
        steps(2);
        cnt_chk("R5 wrap to zero", 16'h0000);
        rd_chk("R5 overflow flag", A_CTRL, 8'h85);
        check("R9 irq from overflow", irq, 1);
        steps(3);
        rd_chk("R10 flag sticky", A_CTRL, 8'h85);
        wr(A_CTRL, 8'h05);
        rd_chk("R10 software clear", A_CTRL, 8'h05);
        check("R9 irq cleared", irq, 0);
    endtask

    task automatic t_collide;
        wr(A_CTRL, 8'h00);
        set_cnt(16'hFFFF);
        wr(A_CTRL, 8'h05);
        wr(A_CTRL, 8'h05);
        rd_chk("R10 hardware set wins", A_CTRL, 8'h85);
        wr(A_CTRL, 8'h00);
        set_cnt(16'hFFFF);
        wr(A_CTRL, 8'h05);
        wr(A_CNT_HI, 8'hFF);
        cnt_chk("R11 write drops step", 16'hFFFF);
        rd_chk("R11 no overflow", A_CTRL, 8'h05);
        steps(1);
        rd_chk("R11 next step wraps", A_CTRL, 8'h85);
        wr(A_CTRL, 8'h00);
        set_cnt(16'h1200);
        wr(A_CTRL, 8'h04);
        steps(3);
        wr(A_CNT_LO, 8'h80);
        cnt_chk("R11 byte replaced", 16'h1280);
        steps(1);
        cnt_chk("R11 resumes", 16'h1281);
    endtask

    task automatic t_reload;
        wr(A_CTRL, 8'h00);
        set_cap(16'h1000);
        set_cnt(16'hFFFD);
        wr(A_CTRL, 8'h04);
        steps(2);
        cnt_chk("R6 before wrap", 16'hFFFF);
        steps(1);
        cnt_chk("R6 reload", 16'h1000);
        rd_chk("R6 overflow flag", A_CTRL, 8'h84);
        wr(A_CTRL, 8'h00);
        set_cnt(16'h0042);
        wr(A_CTRL, 8'h0E);
        trig_pin = 1'b0;
        steps(2);
        cnt_chk("R6 trigger reload", 16'h1000);
        rd_chk("R6 external flag", A_CTRL, 8'h4E);
        trig_pin = 1'b1;
        steps(2);
    endtask

    task automatic t_down;
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h01);
        set_cap(16'h0005);
        set_cnt(16'h0007);
        trig_pin = 1'b0;
        steps(2);
        wr(A_CTRL, 8'h04);
        steps(1);
        cnt_chk("R7 count down", 16'h0006);
        steps(1);
        cnt_chk("R7 at reload value", 16'h0005);
        steps(1);
        cnt_chk("R7 underflow", 16'hFFFF);
        rd_chk("R7 flags", A_CTRL, 8'hC4);
        wr(A_CTRL, 8'h00);
        wr(A_CTRL, 8'h40);
        check("R9 ext masked by down-count", irq, 0);
        wr(A_MODE, 8'h00);
        check("R9 ext unmasked", irq, 1);
        wr(A_MODE, 8'h01);
        wr(A_CTRL, 8'h00);
        trig_pin = 1'b1;
        steps(2);
        set_cnt(16'hFFFE);
        wr(A_CTRL, 8'h04);
        steps(1);
        cnt_chk("R7 count up", 16'hFFFF);
        steps(1);
        cnt_chk("R7 up wrap reload", 16'h0005);
        rd_chk("R7 up wrap flags", A_CTRL, 8'hC4);
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h00);
    endtask

    task automatic t_baud;
        wr(A_CTRL, 8'h00);
        set_cap(16'hFF00);
        set_cnt(16'hFFFE);
        wr(A_CTRL, 8'h15);
        steps(1);
        check("R8 no pulse yet", ovf_pulse, 0);
        steps(1);
        cnt_chk("R8 reload", 16'hFF00);
        check("R8 pulse", ovf_pulse, 1);
        rd_chk("R8 no overflow flag", A_CTRL, 8'h15);
        steps(1);
        check("R8 pulse one clock", ovf_pulse, 0);
        steps(255);
        check("R8 pulse period", ovf_pulse, 1);
        wr(A_CTRL, 8'h00);
        set_cnt(16'h0077);
        wr(A_CTRL, 8'h2E);
        trig_pin = 1'b0;
        steps(2);
        cnt_chk("R8 trigger no reload", 16'h0077);
        rd_chk("R8 trigger no flag", A_CTRL, 8'h2E);
        trig_pin = 1'b1;
        steps(2);
        wr(A_CTRL, 8'h00);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        steps(3);
        rst = 1'b0;
        steps(1);
        t_reset();
        t_timer();
        t_counter();
        t_capture();
        t_collide();
        t_reload();
        t_down();
        t_baud();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule